// File: doc/BRIEF.md
# GPIO Edge-Status Register Bank

This block holds three 32-bit registers for the upper GPIO group, pins 63 down to 32. A live level register shows the state of every pin after a two-stage synchroniser. An event-enable register and a write-one-to-clear edge status register serve the sixteen event-capable pins 47 down to 32. Each event-capable pin has its own polarity bit that picks which edge it watches: rising or falling.

A status bit latches when its pin shows the selected edge. It stays set until software writes a 1 to it. The block ANDs each status bit with its enable bit to form a per-pin power-management event request. Downstream logic combines these requests and routes them onward.

Registers are reached through a plain port: byte address, write strobe and write data. Read data is combinational from the address.

Top module: `gpio_edge_bank`

## Requirements
- R1: The level register (offset 14h) returns in bit n the level of pin_i[n]. A change on a pin appears in this register after two rising clock edges.
- R2: A write to the level register has no effect on its contents or on any other register.
- R3: After reset, all of the following hold: the level register reads FFFFFFFFh, the enable register reads 0, the status register reads 0, and pme_o is 0.
- R4: In the enable register (offset 18h), bits 15:0 can be written and read back. Bits 31:16 always read 0.
- R5: Status bit n (offset 1Ch, n = 0..15) sets when pin n shows its selected edge. edge_fall_i[n] = 0 selects rising and 1 selects falling. The opposite edge does not set the bit. Pin n reaches status three clock edges after it changes. Status bits 31:16 always read 0.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R7: If a write-one-to-clear and a new edge event reach the same status bit in the same cycle, the bit stays set.
- R8: pme_o[n] is 1 exactly when status bit n and enable bit n are both 1.
- R9: A read of any offset other than 14h, 18h or 1Ch returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 32 | Asynchronous pin levels, bit n is pin 32+n |
| edge_fall_i | input | 16 | Per-pin edge select, 1 = falling |
| pme_o | output | 16 | Per-pin event requests |

## Verification
Two functions can meet on one status bit in the same clock edge: a detected pin edge and a write-one-to-clear. The bench provokes this on purpose. It changes a pin, waits two clock edges, then issues the clear so that it lands on the very edge where the event latches. The status bit must read 1 afterwards. For comparison, the same clear issued with no event pending must leave the bit at 0.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] prev_q, evt, stat_q;

  // prev resets high to match synchroniser reset: no edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign evt[i] = fall_i[i] ? (prev_q[i] & ~lvl_i[i]) : (~prev_q[i] & lvl_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] & ~clr_i[i]) | evt[i];
    end

    // R5
    status_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(stat_q[i]) && stat_q[i]) |-> $past(evt[i]));
    // R6
    status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(clr_i[i] && !evt[i]) |-> !stat_q[i]);
    // R7
    event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(evt[i]) |-> stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int PIN_N = 32,
  parameter int EVT_N = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [PIN_N-1:0]  pin_i,
  input  logic [EVT_N-1:0]  edge_fall_i,
  output logic [EVT_N-1:0]  pme_o
);
  logic [PIN_N-1:0] lvl;
  logic [EVT_N-1:0] en_q, stat, clr;
  logic             wr_en_reg, wr_stat;

  gpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign wr_en_reg = wr_en_i && (addr_i == OFS_EN);
  assign wr_stat   = wr_en_i && (addr_i == OFS_STAT);
  assign clr       = wr_stat ? wdata_i[EVT_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wdata_i[EVT_N-1:0];
  end

  gpio_edge_stat #(.N(EVT_N)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl[EVT_N-1:0]),
    .fall_i(edge_fall_i),
    .clr_i (clr),
    .stat_o(stat)
  );

  assign pme_o = stat & en_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LEVEL: rdata_o[PIN_N-1:0] = lvl;
      OFS_EN:    rdata_o[EVT_N-1:0] = en_q;
      OFS_STAT:  rdata_o[EVT_N-1:0] = stat;
      default:   rdata_o = '0;
    endcase
  end

  // R4
  en_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_EN) |-> (rdata_o[REG_W-1:EVT_N] == '0));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != OFS_LEVEL && addr_i != OFS_EN && addr_i != OFS_STAT) |-> (rdata_o == '0));
  // R8
  pme_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pme_o[0]) |-> (stat[0] && en_q[0]));
endmodule

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pins = '1;
  logic [15:0] fall = '0, pme;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] old_pins = '1;
  logic [15:0] st_m = '0, en_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_bank u_gpio_edge_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .edge_fall_i(fall), .pme_o(pme)
  );

  function automatic logic [15:0] exp_evt(logic [31:0] o, logic [31:0] n, logic [15:0] f);
    return (f & o[15:0] & ~n[15:0]) | (~f & ~o[15:0] & n[15:0]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle(logic [31:0] p, logic [15:0] f);
    @(negedge clk); pins = p; fall = f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    st_m |= exp_evt(old_pins, p, f);
    old_pins = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R3 reset state
    rd(8'h14, d); check("R3 level", d, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R3 enable", d, 0);
    rd(8'h1C, d); check("R3 status", d, 0);
    check("R3 pme", {16'h0, pme}, 0);

    // R4 enable reserved bits
    wr(8'h18, 32'hFFFF_FFFF); en_m = 16'hFFFF;
    rd(8'h18, d); check("R4 enable", d, 32'h0000_FFFF);

    // R5 directed rising/falling on bit0
    settle(32'hFFFF_FFFE, 16'h0000);
    rd(8'h1C, d); check("R5 falling ignored when rising sel", d, 0);
    settle(32'hFFFF_FFFF, 16'h0000);
    rd(8'h1C, d); check("R5 rising sets", d, 32'h1);
    // R6 write 0 keeps, write 1 clears
    wr(8'h1C, 32'h0); rd(8'h1C, d); check("R6 write0 keeps", d, 32'h1);
    wr(8'h1C, 32'h1); st_m = 0; rd(8'h1C, d); check("R6 write1 clears", d, 0);

    // R7 event and clear on the same edge
    @(negedge clk); pins = 32'hFFFF_FFFE; fall = 16'h0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h1C; wdata = 32'h1; wr_en = 1;
    @(negedge clk); wr_en = 0; old_pins = pins;
    rd(8'h1C, d); check("R7 event wins", d, 32'h1);
    wr(8'h1C, 32'h1); rd(8'h1C, d); check("R7 clear alone", d, 0);
    st_m = 0;

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [31:0] np = $urandom;
      logic [15:0] nf = 16'($urandom);
      settle(np, nf);
      rd(8'h14, d); check("R1 level", d, np);
      rd(8'h1C, d); check("R5 status", d, {16'h0, st_m});
      check("R8 pme", {16'h0, pme}, {16'h0, st_m & en_m});
      case ($urandom % 5)
        0: begin logic [31:0] w = $urandom; wr(8'h18, w); en_m = w[15:0];
             rd(8'h18, d); check("R4 enable rw", d, {16'h0, en_m}); end
        1: begin logic [31:0] w = $urandom; wr(8'h1C, w); st_m &= ~w[15:0];
             rd(8'h1C, d); check("R6 w1c", d, {16'h0, st_m}); end
        2: begin wr(8'h14, ~np); rd(8'h14, d); check("R2 level write ignored", d, np);
             rd(8'h1C, d); check("R2 status untouched", d, {16'h0, st_m});
             rd(8'h18, d); check("R2 enable untouched", d, {16'h0, en_m}); end
        3: begin logic [7:0] a = 8'($urandom);
             if (a != 8'h14 && a != 8'h18 && a != 8'h1C) begin
               rd(a, d); check("R9 unmapped", d, 0);
             end end
        default: ;
      endcase
      check("R8 pme after access", {16'h0, pme}, {16'h0, st_m & en_m});
    end
    finish_run();
  end
endmodule